// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This unit picks the smaller or the larger of two IEEE-754 operands. The operands are either binary32 or binary64 and share one 64-bit word per operand. A format input chooses the width. A function input chooses the direction: 0 asks for the minimum and 1 asks for the maximum. The selection follows the minimumNumber/maximumNumber rules:

- A NaN never wins over a number.
- Two NaNs collapse to the canonical quiet NaN.
- Negative zero orders below positive zero.

The datapath is a single combinational cycle, with an optional output register chosen by a parameter. Beside the result it produces a 5-bit exception-flag vector in which only the invalid-operation bit can ever be set. An execution pipeline would place it in the slot for sign-manipulating and comparison operations.

Top module: `fpsel_minmax`

## Requirements
- R1: With two ordered operands, function 0 returns the numerically lesser operand and function 1 returns the greater one. When the two values are equal, the result equals that value.
- R2: For two negative operands, the one with the larger magnitude is the lesser.
- R3: When the signs differ and the operands are not both zero, the negative operand is the lesser.
- R4: When both operands are zeros, the minimum returns the negative-signed zero if one is present, and the maximum returns the positive-signed zero if one is present.
- R5: When exactly one operand is a NaN (quiet or signalling), the result is the other operand, bit for bit.
- R6: When both operands are NaNs, the result is the canonical quiet NaN: 0x000000007FC00000 in single format and 0x7FF8000000000000 in double format.
- R7: Flags are {invalid, divide-by-zero, overflow, underflow, inexact}, with invalid at bit 4. Bit 4 is 1 exactly when at least one operand is a signalling NaN, that is, an all-ones exponent, a non-zero fraction and the fraction MSB at 0. Quiet NaNs alone leave it at 0. Bits 3..0 are always 0.
- R8: Format 0 (single) uses only bits [31:0] of each operand; bits [63:32] of the inputs are ignored and bits [63:32] of the result are 0. Format 1 (double) uses all 64 bits.
- R9: With the output register enabled (the default), the result and flags appear one clock after the inputs are applied. While reset is asserted, the result and flags are all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_a_i | input | 64 | First operand word |
| op_b_i | input | 64 | Second operand word |
| fmt_i | input | 1 | 0 = binary32 in bits [31:0], 1 = binary64 |
| op_i | input | 1 | 0 = minimum, 1 = maximum |
| res_o | output | 64 | Selected result |
| flags_o | output | 5 | Exception flags, invalid at bit 4 |

## Verification
The embedded properties check the following on every cycle:

- The upper half of the result stays zero in single format.
- Any non-NaN outcome equals one of the two operands.
- Two NaNs always produce the canonical pattern.
- The four non-invalid flag bits never rise.
- The registered output tracks the combinational value with one cycle of delay.

Only the bench scenarios can show that the correct operand was chosen in each case: ordering between two negatives, between mixed signs and between signed zeros, which operand survives next to a NaN, and the difference between quiet and signalling NaNs in the invalid flag.

// File: rtl/fpsel_pkg.sv
package fpsel_pkg;

    parameter int unsigned WORD_W = 64;
    parameter int unsigned HALF_W = 32;
    parameter int unsigned FLAG_W = 5;

    typedef enum logic {
        FMT_SINGLE = 1'b0,
        FMT_DOUBLE = 1'b1
    } fmt_e;

    typedef enum logic {
        SEL_MIN = 1'b0,
        SEL_MAX = 1'b1
    } sel_e;

    // Bit 4 (MSB) is invalid-operation.
    typedef struct packed {
        logic nv;
        logic dz;
        logic of;
        logic uf;
        logic nx;
    } fflags_t;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        fflags_t           flags;
    } sel_out_t;

    localparam logic [WORD_W-1:0] CANON_SP = 64'h0000_0000_7FC0_0000;
    localparam logic [WORD_W-1:0] CANON_DP = 64'h7FF8_0000_0000_0000;

endpackage

// File: rtl/fpsel_classify.sv
module fpsel_classify
    import fpsel_pkg::*;
#(
    parameter int unsigned SP_EXP  = 8,
    parameter int unsigned SP_FRAC = 23,
    parameter int unsigned DP_EXP  = 11,
    parameter int unsigned DP_FRAC = 52
) (
    input  logic [WORD_W-1:0] word_i,
    input  fmt_e              fmt_i,
    output logic              nan_o,
    output logic              snan_o,
    output logic              sign_o,
    output logic [WORD_W-2:0] mag_o
);
    localparam int unsigned SP_W = 1 + SP_EXP + SP_FRAC;
    localparam int unsigned DP_W = 1 + DP_EXP + DP_FRAC;
    localparam int unsigned PAD  = DP_W - SP_W;

    logic sp_exp_ones, sp_frac_nz, sp_quiet;
    logic dp_exp_ones, dp_frac_nz, dp_quiet;

    always_comb begin
        sp_exp_ones = &word_i[SP_W-2 -: SP_EXP];
        sp_frac_nz  = |word_i[SP_FRAC-1:0];
        sp_quiet    = word_i[SP_FRAC-1];
        dp_exp_ones = &word_i[DP_W-2 -: DP_EXP];
        dp_frac_nz  = |word_i[DP_FRAC-1:0];
        dp_quiet    = word_i[DP_FRAC-1];

        if (fmt_i == FMT_DOUBLE) begin
            nan_o  = dp_exp_ones && dp_frac_nz;
            snan_o = dp_exp_ones && dp_frac_nz && !dp_quiet;
            sign_o = word_i[DP_W-1];
            mag_o  = word_i[DP_W-2:0];
        end else begin
            nan_o  = sp_exp_ones && sp_frac_nz;
            snan_o = sp_exp_ones && sp_frac_nz && !sp_quiet;
            sign_o = word_i[SP_W-1];
            mag_o  = {{PAD{1'b0}}, word_i[SP_W-2:0]};
        end
    end
endmodule

// File: rtl/fpsel_order.sv
module fpsel_order #(
    parameter int unsigned MAG_W = 63
) (
    input  logic             a_sign_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             b_sign_i,
    input  logic [MAG_W-1:0] b_mag_i,
    output logic             a_lt_b_o
);
    // Sign-magnitude ordering; -0 ranks below +0 by its sign alone.
    always_comb begin
        if (a_sign_i != b_sign_i)
            a_lt_b_o = a_sign_i;
        else if (a_sign_i)
            a_lt_b_o = a_mag_i > b_mag_i;
        else
            a_lt_b_o = a_mag_i < b_mag_i;
    end
endmodule

// File: rtl/fpsel_minmax.sv
module fpsel_minmax
    import fpsel_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [63:0]       op_a_i,
    input  logic [63:0]       op_b_i,
    input  logic              fmt_i,
    input  logic              op_i,
    output logic [63:0]       res_o,
    output logic [4:0]        flags_o
);
    localparam int unsigned MAG_W = WORD_W - 1;
    localparam int unsigned NOPS  = 2;

    fmt_e fmt;
    sel_e sel;
    assign fmt = fmt_e'(fmt_i);
    assign sel = sel_e'(op_i);

    logic [WORD_W-1:0] word_raw [NOPS];
    logic [WORD_W-1:0] word_fmt [NOPS];
    logic              is_nan   [NOPS];
    logic              is_snan  [NOPS];
    logic              sgn      [NOPS];
    logic [MAG_W-1:0]  mag      [NOPS];
    logic              a_lt_b;

    assign word_raw[0] = op_a_i;
    assign word_raw[1] = op_b_i;

    for (genvar i = 0; i < NOPS; i++) begin : g_opnd
        fpsel_classify u_cls (
            .word_i (word_raw[i]),
            .fmt_i  (fmt),
            .nan_o  (is_nan[i]),
            .snan_o (is_snan[i]),
            .sign_o (sgn[i]),
            .mag_o  (mag[i])
        );
        assign word_fmt[i] = (fmt == FMT_DOUBLE) ? word_raw[i]
                           : {{(WORD_W-HALF_W){1'b0}}, word_raw[i][HALF_W-1:0]};
    end

    fpsel_order #(.MAG_W(MAG_W)) u_ord (
        .a_sign_i (sgn[0]),
        .a_mag_i  (mag[0]),
        .b_sign_i (sgn[1]),
        .b_mag_i  (mag[1]),
        .a_lt_b_o (a_lt_b)
    );

    sel_out_t out_d, out_q;

    always_comb begin
        out_d          = '0;
        out_d.flags.nv = is_snan[0] | is_snan[1];
        if (is_nan[0] && is_nan[1])
            out_d.res = (fmt == FMT_DOUBLE) ? CANON_DP : CANON_SP;
        else if (is_nan[0])
            out_d.res = word_fmt[1];
        else if (is_nan[1])
            out_d.res = word_fmt[0];
        else if (sel == SEL_MIN)
            out_d.res = a_lt_b ? word_fmt[0] : word_fmt[1];
        else
            out_d.res = a_lt_b ? word_fmt[1] : word_fmt[0];
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) out_q <= '0;
            else         out_q <= out_d;
        end

        p_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) |-> out_q == $past(out_d));
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign res_o   = out_q.res;
    assign flags_o = out_q.flags;

    p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fmt == FMT_SINGLE) |-> out_d.res[WORD_W-1:HALF_W] == '0);

    p_pick_operand_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(is_nan[0] && is_nan[1]) |-> (out_d.res == word_fmt[0] || out_d.res == word_fmt[1]));

    p_both_nan_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_nan[0] && is_nan[1]) |-> (out_d.res == CANON_SP || out_d.res == CANON_DP));

    p_quiet_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o[3:0] == 4'b0);

    p_zero_min_neg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!is_nan[0] && !is_nan[1] && mag[0] == '0 && mag[1] == '0 && sel == SEL_MIN
         && (sgn[0] || sgn[1])) |-> out_d.res[(fmt == FMT_DOUBLE) ? WORD_W-1 : HALF_W-1]);
endmodule

// File: tb/fpsel_minmax_bench.sv
module fpsel_minmax_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a = '0, b = '0;
    logic        fmt = 1'b0, op = 1'b0;
    logic [63:0] res;
    logic [4:0]  flags;

    always #2 clk = ~clk;   // 250 MHz

    fpsel_minmax u_fpsel_minmax (
        .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b),
        .fmt_i(fmt), .op_i(op), .res_o(res), .flags_o(flags)
    );

    typedef struct {
        logic [63:0] res;
        logic [4:0]  flags;
        string       tag;
        int          cyc;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item issued before the latest rising edge.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].cyc < cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (res !== it.res || flags !== it.flags) begin
                errors++;
                $display("FAIL %s: got res=%h flags=%b, expected res=%h flags=%b",
                         it.tag, res, flags, it.res, it.flags);
            end
        end
    end

    task automatic drive(input logic [63:0] va, input logic [63:0] vb,
                         input logic vf, input logic vo,
                         input logic [63:0] er, input logic [4:0] ef, input string tag);
        item_t it;
        @(negedge clk);
        a = va; b = vb; fmt = vf; op = vo;
        it.res = er; it.flags = ef; it.tag = tag; it.cyc = cyc;
        q.push_back(it);
    endtask

    localparam logic [4:0] NV = 5'b10000;

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res !== 64'h0 || flags !== 5'h0) begin
            errors++;
            $display("FAIL R9 reset: got res=%h flags=%b, expected 0/0", res, flags);
        end
        rst_n = 1'b1;

        drive(64'h3F800000, 64'h40000000, 0, 0, 64'h3F800000, 0, "R1 min(1,2)");
        drive(64'h3F800000, 64'h40000000, 0, 1, 64'h40000000, 0, "R1 max(1,2)");
        drive(64'h3F800000, 64'h3F800000, 0, 1, 64'h3F800000, 0, "R1 max equal");
        drive(64'hBF800000, 64'hC0000000, 0, 1, 64'hBF800000, 0, "R2 max(-1,-2)");
        drive(64'hBF800000, 64'hC0000000, 0, 0, 64'hC0000000, 0, "R2 min(-1,-2)");
        drive(64'h40000000, 64'hBF800000, 0, 0, 64'hBF800000, 0, "R3 min(2,-1)");
        drive(64'hBF800000, 64'h40000000, 0, 1, 64'h40000000, 0, "R3 max(-1,2)");
        drive(64'hFF800000, 64'h3F800000, 0, 0, 64'hFF800000, 0, "R3 min(-inf,1)");
        drive(64'h00000000, 64'h80000000, 0, 0, 64'h80000000, 0, "R4 min(+0,-0)");
        drive(64'h80000000, 64'h00000000, 0, 1, 64'h00000000, 0, "R4 max(-0,+0)");
        drive(64'h7FC00000, 64'h40000000, 0, 0, 64'h40000000, 0, "R5 min(qnan,2)");
        drive(64'h7F800001, 64'h3F800000, 0, 1, 64'h3F800000, NV, "R5 R7 max(snan,1)");
        drive(64'hC0000000, 64'hFFC00000, 0, 1, 64'hC0000000, 0, "R5 max(-2,-qnan)");
        drive(64'h7FC00000, 64'h7F800001, 0, 0, 64'h7FC00000, NV, "R6 R7 min(qnan,snan)");
        drive(64'h7FC00000, 64'hFFC00000, 0, 1, 64'h7FC00000, 0, "R6 R7 max(qnan,qnan)");
        drive(64'hDEADBEEF_3F800000, 64'h12345678_40000000, 0, 1,
              64'h00000000_40000000, 0, "R8 upper bits ignored");
        drive(64'h4000000000000000, 64'hC008000000000000, 1, 0,
              64'hC008000000000000, 0, "R8 R3 dbl min(2,-3)");
        drive(64'h3FF0000000000000, 64'h4000000000000000, 1, 1,
              64'h4000000000000000, 0, "R8 R1 dbl max(1,2)");
        drive(64'h7FF0000000000001, 64'h7FF0000000000001, 1, 0,
              64'h7FF8000000000000, NV, "R6 dbl both snan");
        drive(64'h7FF8000000000000, 64'h8000000000000000, 1, 1,
              64'h8000000000000000, 0, "R5 dbl max(qnan,-0)");
        drive(64'h0000000000000000, 64'h8000000000000000, 1, 0,
              64'h8000000000000000, 0, "R4 dbl min(+0,-0)");
        drive(64'h7FC00000_00000000, 64'h3FF0000000000000, 1, 0,
              64'h3FF0000000000000, 0, "R8 dbl uses upper half");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (2000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R9 pending results: got %0d, expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule